// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Short-Circuit Latch

This block sits between the two switch commands of one half-bridge leg and the two gate enables that drive it. It stops both switches from conducting together. When the command moves from one side to the other, it holds both gates off for a programmable dead interval. A leg that receives both commands at once, a high sleep input or a high disable input is parked with both gates off. With both gates off the leg output floats. With only the upper gate on, the output follows the positive rail. With only the lower gate on, it follows the negative rail.

Each switch has a digital desaturation input, which stands in for the analog short detector. That input is looked at only while its own gate is on and a blanking interval has passed since turn-on. A qualified short turns the gate off and latches an active-low fault flag. The fault clears in one of two ways. In manual mode, the disable input must be held low for a minimum number of cycles. In automatic mode, a retry timer clears it. In automatic mode the leg retries again and again for as long as the short is there. All intervals are parameters counted in clock cycles.

Top module: `hb_gate_ctrl`

## Requirements
- R1: During and right after reset, `gate_hi` and `gate_lo` are 0 and `flt_n` is 1.
- R2: If only `cmd_hi` is requested and both gates have been off for at least `DEAD_CYC` cycles, `gate_hi` is 1 after the next clock edge. When the command drops, the gate turns off after the next edge. `cmd_lo` and `gate_lo` behave the same way.
- R3: The two gates are never on together. After one gate turns off, the other turns on at the `DEAD_CYC`-th clock edge after the turn-off edge, and no earlier.
- R4: While `cmd_hi` and `cmd_lo` are both 1, both gates are 0 from the next edge on.
- R5: While `sleep` is 1 or `dis_clr` is 1, both gates are 0 from the next edge on, whatever the commands are.
- R6: A desaturation input is ignored while its gate is off and during the first `BLANK_CYC` cycles after that gate turns on.
- R7: A desaturation input that is 1 during the (`BLANK_CYC`+1)-th cycle of its gate's on-time, or later, turns that gate off and drives `flt_n` to 0 at the same next edge.
- R8: While `flt_n` is 0, both gates stay 0 whatever the commands do.
- R9: With `auto_rt_n` = 1 (manual mode), the fault clears at the `RST_MIN_CYC`-th consecutive clock edge that samples `dis_clr` low, counted after `dis_clr` was last high. A shorter low pulse leaves `flt_n` at 0.
- R10: With `auto_rt_n` = 0 (automatic mode), `flt_n` stays 0 for exactly `RETRY_CYC` cycles and then returns to 1, and a `dis_clr` pulse does not shorten that time. If the gate is still commanded it turns on again, and a short that is still present trips it again, as many times as needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_hi | input | 1 | Upper switch command |
| cmd_lo | input | 1 | Lower switch command |
| sleep | input | 1 | 1 parks both gates off |
| dis_clr | input | 1 | 1 disables the drive; a long enough low run clears a manual fault |
| auto_rt_n | input | 1 | 0 selects automatic retry, 1 selects manual clear |
| desat_hi | input | 1 | Short indication from the upper switch |
| desat_lo | input | 1 | Short indication from the lower switch |
| gate_hi | output | 1 | Upper gate enable |
| gate_lo | output | 1 | Lower gate enable |
| flt_n | output | 1 | Short-circuit flag, active low |

## Verification
Gate turn-off on a command, sleep or disable change is due one edge after the change. Turn-on after a swap of sides is due at exactly the `DEAD_CYC`-th edge after the turn-off. A held short trips at edge `BLANK_CYC`+1 after turn-on. A manual clear lands on the `RST_MIN_CYC`-th low sample of `dis_clr`. An automatic clear comes after exactly `RETRY_CYC` low cycles of `flt_n`. The bench changes inputs and samples outputs on the falling clock edge and counts edges from the stimulus to the expected change. It checks both the cycle before and the cycle of each change, so an off-by-one in any counter shows up as a mismatch.

// File: rtl/hb_pkg.sv
// Package: shared side indices and counter-width helper for the half-bridge
// gate sequencer. Assumes at most two switches per leg.
package hb_pkg;

    typedef enum int {
        SIDE_HI = 0,
        SIDE_LO = 1
    } hb_side_e;

    localparam int HB_SIDES = 2;

    // Width of a counter that must hold values 0..limit.
    function automatic int cnt_w(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/hb_blank_qual.sv
// Module: desaturation qualifier for one switch.
// Counts on-time of its gate and passes the desat input through only once
// the gate has been on for BLANK_CYC cycles. Assumes gate_on is a register
// output and desat is synchronous to clk.
module hb_blank_qual #(
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    input  logic desat,
    output logic trip
);
    import hb_pkg::*;

    generate
        if (BLANK_CYC == 0) begin : g_noblank
            // Qualify: no blanking, any desat while on trips
            always_comb trip = gate_on & desat;
        end else begin : g_blank
            localparam int CW = cnt_w(BLANK_CYC);
            localparam logic [CW-1:0] CMAX = CW'(BLANK_CYC);
            logic [CW-1:0] on_cnt;

            // On-time counter, saturating at the blanking length
            always_ff @(posedge clk) begin
                if (!rst_n)              on_cnt <= '0;
                else if (!gate_on)       on_cnt <= '0;
                else if (on_cnt != CMAX) on_cnt <= on_cnt + 1'b1;
            end

            // Qualify: desat counts only after blanking has elapsed
            always_comb trip = gate_on & desat & (on_cnt == CMAX);
        end
    endgenerate

endmodule

// File: rtl/hb_dead_arbiter.sv
// Module: dead-time arbiter for the two gates of one leg.
// A gate may rise only when both gates have been off for DEAD_CYC cycles;
// a gate falls on the edge after its request drops or it trips. Assumes
// the request vector never has both bits set (the top masks that case).
module hb_dead_arbiter #(
    parameter int DEAD_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] want,
    input  logic [1:0] kill,
    output logic [1:0] gate
);
    import hb_pkg::*;

    localparam int DLIM = (DEAD_CYC < 1) ? 1 : DEAD_CYC;
    localparam int CW = cnt_w(DLIM);
    localparam logic [CW-1:0] CMAX  = CW'(DLIM);
    localparam logic [CW-1:0] CLAST = CW'(DLIM - 1);

    logic [CW-1:0] idle_cnt;
    logic          both_off;
    logic          idle_ok;
    logic [1:0]    gate_d;

    // Idle detect: both gates currently off
    always_comb both_off = (gate == 2'b00);

    // Idle-time counter, cleared while any gate conducts
    always_ff @(posedge clk) begin
        if (!rst_n)                idle_cnt <= '0;
        else if (!both_off)        idle_cnt <= '0;
        else if (idle_cnt != CMAX) idle_cnt <= idle_cnt + 1'b1;
    end

    // Dead interval satisfied on this edge
    always_comb idle_ok = both_off & (idle_cnt >= CLAST);

    genvar s;
    generate
        for (s = 0; s < HB_SIDES; s++) begin : g_side
            // Next gate state: hold while requested, start only after dead time
            always_comb
                gate_d[s] = want[s] & ~kill[s] & (gate[s] | idle_ok);

            // Gate register
            always_ff @(posedge clk) begin
                if (!rst_n) gate[s] <= 1'b0;
                else        gate[s] <= gate_d[s];
            end
        end
    endgenerate

endmodule

// File: rtl/hb_fault_ctl.sv
// Module: short-circuit fault latch with manual and automatic clearing.
// Sets on a qualified trip. In manual mode (auto_n high) clears after
// RST_MIN_CYC consecutive low samples of dis_clr; in automatic mode clears
// after RETRY_CYC cycles. Assumes trip cannot occur while latched.
module hb_fault_ctl #(
    parameter int RETRY_CYC   = 4_000_000,
    parameter int RST_MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic dis_clr,
    input  logic auto_n,
    output logic fault
);
    import hb_pkg::*;

    localparam int RLIM = (RETRY_CYC < 1) ? 1 : RETRY_CYC;
    localparam int LLIM = (RST_MIN_CYC < 1) ? 1 : RST_MIN_CYC;
    localparam int RW = cnt_w(RLIM);
    localparam int LW = cnt_w(LLIM);
    localparam logic [RW-1:0] R_LAST = RW'(RLIM - 1);
    localparam logic [LW-1:0] L_MAX  = LW'(LLIM);
    localparam logic [LW-1:0] L_LAST = LW'(LLIM - 1);

    logic [RW-1:0] retry_cnt;
    logic [LW-1:0] low_cnt;
    logic          man_clr;
    logic          auto_clr;

    // Consecutive-low counter on the disable input, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt <= '0;
        else if (dis_clr)        low_cnt <= '0;
        else if (low_cnt != L_MAX) low_cnt <= low_cnt + 1'b1;
    end

    // Retry timer, runs only while latched in automatic mode
    always_ff @(posedge clk) begin
        if (!rst_n)                 retry_cnt <= '0;
        else if (fault && !auto_n)  retry_cnt <= (retry_cnt == R_LAST) ? '0 : retry_cnt + 1'b1;
        else                        retry_cnt <= '0;
    end

    // Clear conditions for the two modes
    always_comb begin
        man_clr  = fault &  auto_n & ~dis_clr & (low_cnt == L_LAST);
        auto_clr = fault & ~auto_n & (retry_cnt == R_LAST);
    end

    // Fault latch, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                  fault <= 1'b0;
        else if (trip)               fault <= 1'b1;
        else if (man_clr || auto_clr) fault <= 1'b0;
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
// Module: half-bridge gate sequencer, top level.
// Masks the switch commands with sleep, disable, fault and the both-on
// case, inserts dead time, blanks the desaturation inputs and latches
// shorts into an active-low flag. All inputs are assumed synchronous.
module hb_gate_ctrl #(
    parameter int DEAD_CYC    = 100,
    parameter int BLANK_CYC   = 20,
    parameter int RETRY_CYC   = 4_000_000,
    parameter int RST_MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic sleep,
    input  logic dis_clr,
    input  logic auto_rt_n,
    input  logic desat_hi,
    input  logic desat_lo,
    output logic gate_hi,
    output logic gate_lo,
    output logic flt_n
);
    import hb_pkg::*;

    logic [1:0] cmd_v;
    logic [1:0] desat_v;
    logic [1:0] want;
    logic [1:0] trip_v;
    logic [1:0] gate_v;
    logic       fault;
    logic       park;

    // Pack side signals into vectors indexed by side
    always_comb begin
        cmd_v[SIDE_HI]   = cmd_hi;
        cmd_v[SIDE_LO]   = cmd_lo;
        desat_v[SIDE_HI] = desat_hi;
        desat_v[SIDE_LO] = desat_lo;
    end

    // Park condition: any reason that forces both gates off
    always_comb park = sleep | dis_clr | fault | (cmd_hi & cmd_lo);

    // Masked requests
    always_comb want = park ? 2'b00 : cmd_v;

    hb_dead_arbiter #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .want  (want),
        .kill  (trip_v),
        .gate  (gate_v)
    );

    genvar s;
    generate
        for (s = 0; s < HB_SIDES; s++) begin : g_qual
            hb_blank_qual #(.BLANK_CYC(BLANK_CYC)) u_qual (
                .clk     (clk),
                .rst_n   (rst_n),
                .gate_on (gate_v[s]),
                .desat   (desat_v[s]),
                .trip    (trip_v[s])
            );
        end
    endgenerate

    hb_fault_ctl #(
        .RETRY_CYC   (RETRY_CYC),
        .RST_MIN_CYC (RST_MIN_CYC)
    ) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (|trip_v),
        .dis_clr (dis_clr),
        .auto_n  (auto_rt_n),
        .fault   (fault)
    );

    // Drive outputs
    always_comb begin
        gate_hi = gate_v[SIDE_HI];
        gate_lo = gate_v[SIDE_LO];
        flt_n   = ~fault;
    end

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
// Module: property checker for hb_gate_ctrl, attached by bind.
// Keeps its own count of cycles with both gates off to check the dead gap.
module hb_gate_ctrl_chk #(
    parameter int DEAD_CYC = 100
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_hi,
    input logic cmd_lo,
    input logic sleep,
    input logic dis_clr,
    input logic desat_hi,
    input logic desat_lo,
    input logic gate_hi,
    input logic gate_lo,
    input logic flt_n
);
    localparam int DLIM = (DEAD_CYC < 1) ? 1 : DEAD_CYC;
    localparam int CW = $clog2(DLIM + 1);
    localparam logic [CW-1:0] CMAX = CW'(DLIM);

    logic [CW-1:0] off_run;

    // Count cycles with both gates off, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                off_run <= '0;
        else if (gate_hi || gate_lo) off_run <= '0;
        else if (off_run != CMAX)  off_run <= off_run + 1'b1;
    end

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));

    a_r3_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_hi) || $rose(gate_lo)) |-> (off_run >= CMAX));

    a_r4_both_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hi && cmd_lo) |=> (!gate_hi && !gate_lo));

    a_r5_park_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep || dis_clr) |=> (!gate_hi && !gate_lo));

    a_r7_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flt_n) |-> $past((desat_hi && gate_hi) || (desat_lo && gate_lo)));

    a_r8_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_n |-> (!gate_hi && !gate_lo));

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_hi   (cmd_hi),
    .cmd_lo   (cmd_lo),
    .sleep    (sleep),
    .dis_clr  (dis_clr),
    .desat_hi (desat_hi),
    .desat_lo (desat_lo),
    .gate_hi  (gate_hi),
    .gate_lo  (gate_lo),
    .flt_n    (flt_n)
);

// File: tb/test_hb_gate_ctrl.sv
// Directed bench for hb_gate_ctrl: one task per scenario, inputs driven
// and outputs sampled on the falling clock edge.
module test_hb_gate_ctrl;

    localparam int DEAD  = 8;
    localparam int BLANK = 3;
    localparam int RETRY = 50;
    localparam int RMIN  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_hi = 1'b0, cmd_lo = 1'b0, sleep = 1'b0, dis_clr = 1'b0;
    logic auto_rt_n = 1'b1, desat_hi = 1'b0, desat_lo = 1'b0;
    logic gate_hi, gate_lo, flt_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hb_gate_ctrl #(
        .DEAD_CYC(DEAD), .BLANK_CYC(BLANK), .RETRY_CYC(RETRY), .RST_MIN_CYC(RMIN)
    ) i_hb_gate_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .sleep(sleep), .dis_clr(dis_clr), .auto_rt_n(auto_rt_n),
        .desat_hi(desat_hi), .desat_lo(desat_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .flt_n(flt_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Pack outputs as {gate_hi, gate_lo, flt_n}
    function automatic int outs();
        return {29'd0, gate_hi, gate_lo, flt_n};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        step(3);
        check("R1 outputs in reset", outs(), 3'b001);
        rst_n = 1'b1;
        step(1);
        check("R1 outputs after reset", outs(), 3'b001);
        step(DEAD + 2);
    endtask

    task automatic t_single();
        cmd_hi = 1'b1;
        step(1);
        check("R2 upper on", outs(), 3'b101);
        cmd_hi = 1'b0;
        step(1);
        check("R2 upper off", outs(), 3'b001);
        step(DEAD + 2);
        cmd_lo = 1'b1;
        step(1);
        check("R2 lower on", outs(), 3'b011);
        cmd_lo = 1'b0;
        step(DEAD + 2);
    endtask

    task automatic t_dead();
        cmd_hi = 1'b1;
        step(2);
        check("R2 upper held", outs(), 3'b101);
        cmd_hi = 1'b0;
        cmd_lo = 1'b1;
        for (int k = 0; k <= DEAD; k++) begin
            step(1);
            check("R3 lower edge after dead time", outs(), (k == DEAD) ? 3'b011 : 3'b001);
        end
    endtask

    task automatic t_both();
        cmd_hi = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1);
            check("R4 both commands park", outs(), 3'b001);
        end
        cmd_hi = 1'b0;
        cmd_lo = 1'b0;
        step(DEAD + 2);
    endtask

    task automatic t_block();
        cmd_hi = 1'b1;
        step(1);
        check("R2 upper on before sleep", outs(), 3'b101);
        sleep = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step(1);
            check("R5 sleep parks", outs(), 3'b001);
        end
        sleep = 1'b0;
        step(DEAD + 2);
        check("R5 resumes after sleep", outs(), 3'b101);
        dis_clr = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step(1);
            check("R5 disable parks", outs(), 3'b001);
        end
        dis_clr = 1'b0;
        cmd_hi = 1'b0;
        step(DEAD + 2);
    endtask

    task automatic t_blank_trip();
        desat_hi = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step(1);
            check("R6 desat ignored while off", outs(), 3'b001);
        end
        cmd_hi = 1'b1;
        for (int k = 0; k <= BLANK + 1; k++) begin
            step(1);
            check("R6 R7 blanking then trip", outs(), (k <= BLANK) ? 3'b101 : 3'b000);
        end
        desat_hi = 1'b0;
        for (int k = 0; k < 6; k++) begin
            cmd_hi = k[0];
            cmd_lo = ~k[0];
            step(1);
            check("R8 gates held off in fault", outs(), 3'b000);
        end
        cmd_hi = 1'b0;
        cmd_lo = 1'b0;
    endtask

    task automatic t_manual_clr();
        auto_rt_n = 1'b1;
        dis_clr = 1'b1;
        step(2);
        dis_clr = 1'b0;
        step(RMIN - 1);
        dis_clr = 1'b1;
        step(1);
        check("R9 short low pulse keeps fault", outs(), 3'b000);
        dis_clr = 1'b0;
        for (int k = 0; k < RMIN; k++) begin
            step(1);
            check("R9 clear on last low sample", outs(), (k == RMIN - 1) ? 3'b001 : 3'b000);
        end
        cmd_lo = 1'b1;
        step(1);
        check("R9 drive re-enabled", outs(), 3'b011);
        cmd_lo = 1'b0;
        step(DEAD + 2);
    endtask

    // Count cycles flt_n is low, starting on a sample where it is low
    task automatic measure_low(input bit pulse, output int len);
        len = 1;
        while (flt_n == 1'b0 && len < 4 * RETRY) begin
            if (pulse && len == 2) dis_clr = 1'b1;
            if (pulse && len == 3) dis_clr = 1'b0;
            step(1);
            if (flt_n == 1'b0) len++;
        end
    endtask

    task automatic wait_fault();
        for (int k = 0; k < 100 && flt_n == 1'b1; k++) step(1);
    endtask

    task automatic t_auto_retry();
        int len;
        auto_rt_n = 1'b0;
        cmd_lo = 1'b1;
        desat_lo = 1'b1;
        wait_fault();
        check("R7 lower trip", outs(), 3'b000);
        measure_low(1'b0, len);
        check("R10 retry length", len, RETRY);
        step(1);
        check("R10 gate back on after retry", outs(), 3'b011);
        wait_fault();
        check("R10 persistent short trips again", outs(), 3'b000);
        measure_low(1'b1, len);
        check("R10 retry length with ignored reset pulse", len, RETRY);
        desat_lo = 1'b0;
        step(20);
        check("R10 short gone, drive stays on", outs(), 3'b011);
        cmd_lo = 1'b0;
        auto_rt_n = 1'b1;
        step(1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_single();
        t_dead();
        t_both();
        t_block();
        t_blank_trip();
        t_manual_clr();
        t_auto_retry();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule